// File: doc/BRIEF.md
# Multi-Grant Rotating Grant Scheduler

This block is the grant arbiter attached to one output of a partially buffered crossbar. In each time slot it looks at which of the 32 inputs have a cell waiting for its output and hands out as many grants as it has free internal buffers (one to four). Grants go to requesters in circular order. The scan starts at a priority position held in a one-hot pointer. That pointer moves up by one position at the end of every slot, whether or not any grant is accepted downstream. Each output of the switch instantiates its own copy with a different starting pointer, so the outputs do not lock onto the same input.

A slot starts when `slot_i` is sampled high while the block is idle. The request vector and the 3-bit credit code are captured at that point. The block then runs two search phases:
- The upper phase covers requesters at or above the pointer.
- The lower phase wraps around, from position 0 up to just below the pointer, and uses only the credits the upper phase did not consume.

Each phase counts the requests in small chunks and compares running sums against the credit value. This finds the chunk where granting stops, which may be granted only in part. The two partial grant vectors are ORed into the result. The result appears with a one-cycle valid strobe, together with a priority flag taken from the raw credit code.

The controller is a six-state machine:
- `ST_IDLE` goes to `ST_P1_CNT` on an accepted slot.
- `ST_P1_CNT` goes to `ST_P1_CUT`, then to `ST_P2_CNT`, then to `ST_P2_CUT`, then to `ST_MERGE`.
- `ST_MERGE` always returns to `ST_IDLE`, and the pointer advances on that transition.

Top module: `mgrant_sched`

## Requirements
- R1: After reset `ptr_o` is one-hot with its single set bit at position `PTR_INIT`, and it stays one-hot at all times.
- R2: `ptr_o` rotates up by one position (bit N-1 wraps to bit 0) on the same clock edge that raises `gnt_valid_o`, whatever the grant outcome. It holds its value on all other edges.
- R3: A bit of `gnt_o` is set only if the matching bit of the request vector captured for that slot was set.
- R4: The number of set bits in `gnt_o` equals the smaller of the decoded credit count and the number of captured requests.
- R5: Grants go to the first requesters met when scanning upward from the pointer position to bit N-1, then from bit 0 up to the position just below the pointer.
- R6: `credit_i[1:0]` decodes as 01=1, 10=2, 11=3 and 00=4 credits. `credit_i[2]` has no effect on `gnt_o`.
- R7: `prio_o` equals the OR of all three `credit_i` bits captured for the slot.
- R8: If `slot_i` is sampled high in idle at a clock edge, `gnt_o`, `prio_o` and a one-cycle `gnt_valid_o` pulse update on the fifth edge after that one. `gnt_o` and `prio_o` then hold until the next result.
- R9: `slot_i` asserted while a slot is in progress is ignored: no extra result and no extra pointer step.
- R10: A slot with an all-zero request vector yields an all-zero `gnt_o`, and the pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | Starts a slot when sampled high in idle |
| req_i | input | N (32) | Request vector, one bit per input |
| credit_i | input | 3 | Credit code; bits [1:0] give the count, 00 meaning four |
| gnt_o | output | N (32) | Grant vector of the last completed slot |
| gnt_valid_o | output | 1 | One-cycle strobe marking a new `gnt_o` |
| prio_o | output | 1 | OR of the captured credit code bits |
| ptr_o | output | N (32) | One-hot priority pointer |

## Verification
The bench walks the pointer through every position many times. It applies full, empty, sparse and pseudo-random request vectors under all eight credit codes, and compares each grant vector with a circular scan computed in the bench.

- A wrong wrap boundary would grant the pointer's own position twice or skip it. The bench catches this with requests that straddle the pointer and with requesters only below it.
- A bad credit decode would issue zero grants for code 00 or would let bit 2 change the count.
- A phase 2 that ignored the credits already used would over-grant once the vector wraps.
- A controller that accepted a second `slot_i` during a slot would give an extra strobe and a double pointer step.

// File: rtl/mgrant_pkg.sv
package mgrant_pkg;

    localparam int CRW = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_P1_CNT = 3'd1,
        ST_P1_CUT = 3'd2,
        ST_P2_CNT = 3'd3,
        ST_P2_CUT = 3'd4,
        ST_MERGE  = 3'd5
    } mg_state_t;

    // Two-bit credit code to count: zero stands for the full four.
    function automatic logic [CRW-1:0] cred_decode(input logic [1:0] code);
        return (code == 2'b00) ? CRW'(4) : {1'b0, code};
    endfunction

endpackage

// File: rtl/mgrant_ptr.sv
module mgrant_ptr #(
    parameter int N        = 32,
    parameter int PTR_INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [N-1:0] ptr
);

    localparam logic [N-1:0] PTR_RST = N'(1) << PTR_INIT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= PTR_RST;
        end else if (adv) begin
            ptr <= {ptr[N-2:0], ptr[N-1]};
        end
    end

endmodule

// File: rtl/mgrant_chunk_cnt.sv
module mgrant_chunk_cnt #(
    parameter int N      = 32,
    parameter int CW     = 3,
    parameter int NCHUNK = (N + CW - 1) / CW,
    parameter int CCW    = $clog2(CW + 1)
) (
    input  logic [N-1:0]                 vec,
    output logic [NCHUNK-1:0][CCW-1:0]   cnt
);

    for (genvar gc = 0; gc < NCHUNK; gc++) begin : g_chunk
        localparam int LO = gc * CW;
        localparam int HI = (LO + CW > N) ? N - 1 : LO + CW - 1;
        logic [CCW-1:0] sum;

        always_comb begin
            sum = '0;
            for (int b = LO; b <= HI; b++) begin
                sum = sum + CCW'(vec[b]);
            end
        end

        assign cnt[gc] = sum;
    end

endmodule

// File: rtl/mgrant_chunk_cut.sv
module mgrant_chunk_cut
    import mgrant_pkg::*;
#(
    parameter int N      = 32,
    parameter int CW     = 3,
    parameter int NCHUNK = (N + CW - 1) / CW,
    parameter int CCW    = $clog2(CW + 1)
) (
    input  logic [N-1:0]               vec,
    input  logic [NCHUNK-1:0][CCW-1:0] cnt,
    input  logic [CRW-1:0]             credit,
    output logic [N-1:0]               gnt,
    output logic [CRW-1:0]             used
);

    localparam int CNTW = $clog2(N + 1);

    logic [CNTW-1:0]              cred_w;
    logic [CNTW-1:0]              pre;
    logic [CNTW-1:0]              seen;
    logic [NCHUNK-1:0][CNTW-1:0]  rem;

    assign cred_w = CNTW'(credit);

    always_comb begin
        // Running sums of chunk counts against the credit value give,
        // per chunk, how many of its bits may still be granted.
        pre = '0;
        for (int c = 0; c < NCHUNK; c++) begin
            rem[c] = (cred_w > pre) ? (cred_w - pre) : '0;
            pre    = pre + CNTW'(cnt[c]);
        end
        gnt  = '0;
        seen = '0;
        for (int k = 0; k < N; k++) begin
            if (k % CW == 0) begin
                seen = '0;
            end
            if (vec[k] && (seen < rem[k / CW])) begin
                gnt[k] = 1'b1;
                seen   = seen + CNTW'(1);
            end
        end
        used = (cred_w < pre) ? credit : CRW'(pre);
    end

endmodule

// File: rtl/mgrant_sched.sv
module mgrant_sched
    import mgrant_pkg::*;
#(
    parameter int N        = 32,
    parameter int CW       = 3,
    parameter int PTR_INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         slot_i,
    input  logic [N-1:0] req_i,
    input  logic [2:0]   credit_i,
    output logic [N-1:0] gnt_o,
    output logic         gnt_valid_o,
    output logic         prio_o,
    output logic [N-1:0] ptr_o
);

    localparam int NCHUNK = (N + CW - 1) / CW;
    localparam int CCW    = $clog2(CW + 1);

    mg_state_t st_q, st_d;

    logic [N-1:0]               req_hi_q, req_lo_q;
    logic [N-1:0]               lo_mask;
    logic [CRW-1:0]             cred_q, left_q;
    logic [2:0]                 code_q;
    logic [NCHUNK-1:0][CCW-1:0] cnt_q, cnt_w;
    logic [N-1:0]               g1_q, g2_q;
    logic [N-1:0]               cnt_vec, cut_vec, gnt_w;
    logic [CRW-1:0]             cut_cred, used_w;
    logic                       ptr_adv;

    // Pointer
    assign ptr_adv = (st_q == ST_MERGE);

    mgrant_ptr #(.N(N), .PTR_INIT(PTR_INIT)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ptr_adv),
        .ptr   (ptr_o)
    );

    assign lo_mask = ptr_o - N'(1);

    // Shared counter and cutter; the state picks the phase operands.
    assign cnt_vec  = (st_q == ST_P2_CNT) ? req_lo_q : req_hi_q;
    assign cut_vec  = (st_q == ST_P2_CUT) ? req_lo_q : req_hi_q;
    assign cut_cred = (st_q == ST_P2_CUT) ? left_q   : cred_q;

    mgrant_chunk_cnt #(.N(N), .CW(CW), .NCHUNK(NCHUNK), .CCW(CCW)) u_cnt (
        .vec (cnt_vec),
        .cnt (cnt_w)
    );

    mgrant_chunk_cut #(.N(N), .CW(CW), .NCHUNK(NCHUNK), .CCW(CCW)) u_cut (
        .vec    (cut_vec),
        .cnt    (cnt_q),
        .credit (cut_cred),
        .gnt    (gnt_w),
        .used   (used_w)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = slot_i ? ST_P1_CNT : ST_IDLE;
            ST_P1_CNT: st_d = ST_P1_CUT;
            ST_P1_CUT: st_d = ST_P2_CNT;
            ST_P2_CNT: st_d = ST_P2_CUT;
            ST_P2_CUT: st_d = ST_MERGE;
            ST_MERGE:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_hi_q <= '0;
            req_lo_q <= '0;
            cred_q   <= '0;
            code_q   <= '0;
            cnt_q    <= '0;
            g1_q     <= '0;
            g2_q     <= '0;
            left_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (slot_i) begin
                        req_hi_q <= req_i & ~lo_mask;
                        req_lo_q <= req_i & lo_mask;
                        cred_q   <= cred_decode(credit_i[1:0]);
                        code_q   <= credit_i;
                    end
                end
                ST_P1_CNT: cnt_q <= cnt_w;
                ST_P1_CUT: begin
                    g1_q   <= gnt_w;
                    left_q <= cred_q - used_w;
                end
                ST_P2_CNT: cnt_q <= cnt_w;
                ST_P2_CUT: g2_q  <= gnt_w;
                ST_MERGE:  ;
                default:   ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_o       <= '0;
            gnt_valid_o <= 1'b0;
            prio_o      <= 1'b0;
        end else begin
            gnt_valid_o <= (st_q == ST_MERGE);
            if (st_q == ST_MERGE) begin
                gnt_o  <= g1_q | g2_q;
                prio_o <= |code_q;
            end
        end
    end

endmodule

// File: rtl/mgrant_sched_chk.sv
module mgrant_sched_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         slot_i,
    input logic [N-1:0] req_i,
    input logic [2:0]   credit_i,
    input logic [N-1:0] gnt_o,
    input logic         gnt_valid_o,
    input logic         prio_o,
    input logic [N-1:0] ptr_o
);

    logic         busy_c;
    logic [N-1:0] req_c;
    logic [2:0]   code_c;
    logic [3:0]   lat_c;
    int           dec_c;
    int           nreq_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            req_c  <= '0;
            code_c <= '0;
            lat_c  <= '0;
        end else if (slot_i && (!busy_c || gnt_valid_o)) begin
            busy_c <= 1'b1;
            req_c  <= req_i;
            code_c <= credit_i;
            lat_c  <= '0;
        end else begin
            if (gnt_valid_o) busy_c <= 1'b0;
            if (busy_c && lat_c != 4'hF) lat_c <= lat_c + 4'd1;
        end
    end

    assign dec_c  = (code_c[1:0] == 2'b00) ? 4 : int'(code_c[1:0]);
    assign nreq_c = $countones(req_c);

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ptr_o) == 1); // R1

    AST_PTR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> (ptr_o == {$past(ptr_o[N-2:0]), $past(ptr_o[N-1])})); // R2

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid_o |-> $stable(ptr_o)); // R2

    AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> ((gnt_o & ~req_c) == '0)); // R3

    AST_GNT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> ($countones(gnt_o) == ((nreq_c < dec_c) ? nreq_c : dec_c))); // R4

    AST_PRIO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> (prio_o == |code_c)); // R7

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> (busy_c && lat_c == 4'd5)); // R8

    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |=> !gnt_valid_o); // R9

endmodule

bind mgrant_sched mgrant_sched_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_i      (slot_i),
    .req_i       (req_i),
    .credit_i    (credit_i),
    .gnt_o       (gnt_o),
    .gnt_valid_o (gnt_valid_o),
    .prio_o      (prio_o),
    .ptr_o       (ptr_o)
);

// File: tb/mgrant_sched_test.sv
`timescale 1ns/1ps
module mgrant_sched_test;

    localparam int N    = 32;
    localparam int PINI = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         slot_i = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [2:0]   credit_i = '0;
    logic [N-1:0] gnt_o;
    logic         gnt_valid_o;
    logic         prio_o;
    logic [N-1:0] ptr_o;

    int checks = 0;
    int failures = 0;
    int exp_p = PINI;
    bit finished = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2.5 clk = ~clk;

    mgrant_sched #(.N(N), .CW(3), .PTR_INIT(PINI)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_i      (slot_i),
        .req_i       (req_i),
        .credit_i    (credit_i),
        .gnt_o       (gnt_o),
        .gnt_valid_o (gnt_valid_o),
        .prio_o      (prio_o),
        .ptr_o       (ptr_o)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model(input logic [N-1:0] r, input logic [2:0] c, input int p);
        int k = (c[1:0] == 2'b00) ? 4 : int'(c[1:0]);
        logic [N-1:0] g = '0;
        for (int i = 0; i < N; i++) begin
            int idx = (p + i) % N;
            if (r[idx] && k > 0) begin
                g[idx] = 1'b1;
                k--;
            end
        end
        return g;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // One slot; poke re-raises slot_i while the slot is running (R9).
    task automatic do_slot(input logic [N-1:0] r, input logic [2:0] c, input bit poke);
        logic [N-1:0] eg = model(r, c, exp_p);
        logic [N-1:0] nxt_ptr = N'(1) << ((exp_p + 1) % N);
        @(negedge clk);
        slot_i = 1'b1; req_i = r; credit_i = c;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i == 0) begin
                slot_i = poke; req_i = ~r; credit_i = ~c;
            end
            if (i == 3) slot_i = 1'b0;
            chk("R8 valid low in pipeline", N'(gnt_valid_o), '0);
        end
        @(negedge clk);
        chk("R8 valid strobe", N'(gnt_valid_o), N'(1));
        chk("R5 grant vector", gnt_o, eg);
        chk("R7 prio flag", N'(prio_o), N'(|c));
        chk("R2 pointer step", ptr_o, nxt_ptr);
        exp_p = (exp_p + 1) % N;
        @(negedge clk);
        chk("R9 single strobe", N'(gnt_valid_o), '0);
        chk("R8 grant held", gnt_o, eg);
        chk("R9 pointer once", ptr_o, nxt_ptr);
    endtask

    initial begin
        #900000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pointer reset", ptr_o, N'(1) << PINI);
        chk("R8 reset grant", gnt_o, '0);
        chk("R8 reset valid", N'(gnt_valid_o), '0);
        chk("R7 reset prio", N'(prio_o), '0);

        // R10: empty requests still advance the pointer
        do_slot('0, 3'b011, 1'b0);
        chk("R10 zero grants", gnt_o, '0);

        // R4 / R6: all requesters under every code
        for (int c = 0; c < 8; c++) begin
            do_slot('1, 3'(c), 1'b0);
            chk("R4 grant count", N'($countones(gnt_o)), N'((c % 4 == 0) ? 4 : c % 4));
        end

        // R6: bit 2 has no effect on grants
        begin
            logic [N-1:0] ga;
            do_slot(32'hF0F0_0F0F, 3'b010, 1'b0);
            ga = gnt_o;
            repeat (N - 1) do_slot('0, 3'b001, 1'b0);
            do_slot(32'hF0F0_0F0F, 3'b110, 1'b0);
            chk("R6 code bit2 ignored", gnt_o, ga);
        end

        // R5: requesters only below the pointer, and straddling it
        do_slot(N'(1) << ((exp_p + N - 1) % N), 3'b000, 1'b0);
        do_slot((N'(1) << exp_p) | (N'(1) << ((exp_p + N - 2) % N)), 3'b001, 1'b0);
        do_slot(N'(3) << ((exp_p + N - 1) % N) | N'(1) << ((exp_p + 1) % N), 3'b010, 1'b0);

        // R9: slot_i raised while busy
        do_slot(32'h0000_FFFF, 3'b011, 1'b1);
        do_slot(32'hFFFF_0000, 3'b000, 1'b1);

        // R3 / R5 sweep: pseudo-random vectors of several densities
        for (int s = 0; s < 320; s++) begin
            logic [N-1:0] r;
            lfsr = next_rand(lfsr);
            r = lfsr;
            if (s % 3 == 1) begin
                lfsr = next_rand(lfsr);
                r = r & lfsr;
            end
            if (s % 3 == 2) begin
                lfsr = next_rand(lfsr);
                r = r & lfsr;
                lfsr = next_rand(lfsr);
                r = r & lfsr;
            end
            do_slot(r, 3'(s % 8), 1'b0);
            chk("R3 grants within requests", gnt_o & ~r, '0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule